// File: doc/BRIEF.md
# PCI target transaction controller

This block is the target side of a PCI bus interface. It watches the bus for the start of a transaction and captures the address and the bus command from that first cycle. It then checks the address against a small set of memory windows and claims the access when one matches. After the claim, it paces each data phase with the active-low ready strobes and moves the data to or from a simple request/acknowledge port on the local side.

The data path is 32 bits wide. A build-time option adds a 64-bit extension. In that build, the target acknowledges a wide transfer only when the master asked for one during the address phase. If the local side is slow to answer, a latency timer makes the target signal a stop. The master must then end the transaction and retry it later. An access that matches no window, or that carries a command other than memory read or memory write, is left unclaimed. The target ignores it until the bus is idle again.

Top module: `pcit_target`

## Requirements
- R1: Out of reset, `claim_no`, `tgt_rdy_no`, `tgt_stop_no` and `wack_no` are high, and `loc_req_o` and `ad_oe_o` are low.
- R2: The target starts a transaction on a clock edge where it is idle and `cyc_ni` is low. If `ad_i[31:0]` falls inside a window and `cmd_i` is 4'b0110 (memory read) or 4'b0111 (memory write), `claim_no` is low from that edge on. In the same cycle, `loc_addr_o` holds the captured address and `loc_win_o` is one-hot with bit i set for window i. Window i covers the addresses whose bits [31:WIN_BITS] equal those of `WIN_BASE[i]`.
- R3: A start that hits no window, or that carries any other command, leaves `claim_no` high and `loc_req_o` low. This holds until an edge samples `cyc_ni` and `irdy_ni` both high.
- R4: A data word moves only on an edge where `irdy_ni` and `tgt_rdy_no` are both low. For a read, `loc_req_o` is high while the target is not ready. On the edge after `loc_ack_i` is sampled high, `tgt_rdy_no` goes low and `ad_o` holds the `loc_rdata_i` value of that edge. Both hold while `irdy_ni` stays high.
- R5: For a write, `loc_req_o` is high only while `irdy_ni` is low, with `loc_we_o` high and `loc_wdata_o` equal to `ad_i`. `tgt_rdy_no` goes low on the edge after `loc_ack_i`.
- R6: After a transfer with `cyc_ni` low, `loc_addr_o` advances by 4 (32-bit transfer) or 8 (64-bit transfer), and `tgt_rdy_no` returns high.
- R7: `wack_no` is low together with `claim_no` only when the build is wide and `wreq_ni` was low in the address phase. Otherwise it stays high.
- R8: A transfer with `cyc_ni` high is the last one. On the next edge, `claim_no`, `tgt_rdy_no`, `tgt_stop_no` and `wack_no` all return high.
- R9: If `loc_req_o` stays high without `loc_ack_i` for `TMO` consecutive edges, `tgt_stop_no` goes low with `tgt_rdy_no` high. It stays low while `cyc_ni` is low and is released on the edge that samples `cyc_ni` high.
- R10: `tgt_rdy_no` and `tgt_stop_no` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_ni | input | 1 | Transaction strobe from master, active low |
| irdy_ni | input | 1 | Master ready, active low |
| wreq_ni | input | 1 | Master request for 64-bit transfers, active low |
| ad_i | input | DW | Address/data lines seen from the bus |
| cmd_i | input | 4 | Bus command during the address phase |
| ad_o | output | DW | Read data driven to the bus |
| ad_oe_o | output | 1 | Enable for driving `ad_o` |
| claim_no | output | 1 | Device select / claim, active low |
| tgt_rdy_no | output | 1 | Target ready, active low |
| tgt_stop_no | output | 1 | Target stop request, active low |
| wack_no | output | 1 | 64-bit acknowledge, active low |
| loc_req_o | output | 1 | Local access request |
| loc_we_o | output | 1 | Local access is a write |
| loc_addr_o | output | 32 | Local byte address |
| loc_win_o | output | NUM_WIN | One-hot matching window |
| loc_wdata_o | output | DW | Local write data |
| loc_rdata_i | input | DW | Local read data |
| loc_ack_i | input | 1 | Local access complete |

## Verification
The assertions assume a well-behaved master. It starts a transaction only while the bus is idle. Once it drops `irdy_ni`, it keeps it low until a transfer or a stop. After a last transfer or a stop release, it raises `cyc_ni` before `irdy_ni`. They also assume that the local side raises `loc_ack_i` only while `loc_req_o` is high. The directed tasks follow this protocol. Each task drives inputs on the falling edge and returns the bus to idle before the next task begins, so no start overlaps a previous transaction.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_STOP, ST_SKIP} state_e;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/pcit_win_dec.sv
module pcit_win_dec #(
  parameter int NUM_WIN  = 2,
  parameter int WIN_BITS = 12,
  parameter logic [NUM_WIN-1:0][31:0] WIN_BASE = '0
) (
  input  logic [31:WIN_BITS] addr_i,
  output logic [NUM_WIN-1:0] hit_o
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign hit_o[i] = (addr_i == WIN_BASE[i][31:WIN_BITS]);
  end
endmodule

// File: rtl/pcit_tmo.sv
module pcit_tmo #(
  parameter int TMO = 16,
  localparam int CW = $clog2(TMO + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic done_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  assign expire_o = wait_i && !done_i && (cnt_q == CW'(TMO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!wait_i || done_i)  cnt_q <= '0;
    else if (!expire_o)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pcit_target.sv
module pcit_target
  import pcit_pkg::*;
#(
  parameter bit WIDE     = 1'b1,
  parameter int NUM_WIN  = 2,
  parameter int WIN_BITS = 12,
  parameter logic [NUM_WIN-1:0][31:0] WIN_BASE = {32'h0002_0000, 32'h0001_0000},
  parameter int TMO      = 16,
  parameter int DW       = WIDE ? 64 : 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_ni,
  input  logic               irdy_ni,
  input  logic               wreq_ni,
  input  logic [DW-1:0]      ad_i,
  input  logic [3:0]         cmd_i,
  output logic [DW-1:0]      ad_o,
  output logic               ad_oe_o,
  output logic               claim_no,
  output logic               tgt_rdy_no,
  output logic               tgt_stop_no,
  output logic               wack_no,
  output logic               loc_req_o,
  output logic               loc_we_o,
  output logic [31:0]        loc_addr_o,
  output logic [NUM_WIN-1:0] loc_win_o,
  output logic [DW-1:0]      loc_wdata_o,
  input  logic [DW-1:0]      loc_rdata_i,
  input  logic               loc_ack_i
);
  state_e               state_q;
  logic [31:0]          addr_q;
  logic                 we_q, wide_q, rdy_q;
  logic [NUM_WIN-1:0]   win_q, hit;
  logic [DW-1:0]        rdata_q;
  logic                 start, cmd_ok, xfer, expire, wide_req, claimed;
  logic [31:0]          step;

  pcit_win_dec #(.NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)) u_dec (
    .addr_i (ad_i[31:WIN_BITS]),
    .hit_o  (hit)
  );

  if (WIDE) begin : g_wide
    assign wide_req = !wreq_ni;
    assign step     = wide_q ? 32'd8 : 32'd4;
  end else begin : g_narrow
    assign wide_req = 1'b0;
    assign step     = 32'd4;
  end

  assign start   = (state_q == ST_IDLE) && !cyc_ni;
  assign cmd_ok  = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
  assign xfer    = (state_q == ST_DATA) && rdy_q && !irdy_ni;
  assign claimed = (state_q == ST_DATA) || (state_q == ST_STOP);

  assign loc_req_o = (state_q == ST_DATA) && !rdy_q && (!we_q || !irdy_ni);

  pcit_tmo #(.TMO(TMO)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wait_i   (loc_req_o),
    .done_i   (loc_ack_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      rdy_q   <= 1'b0;
      win_q   <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          rdy_q <= 1'b0;
          if (|hit && cmd_ok) begin
            state_q <= ST_DATA;
            addr_q  <= ad_i[31:0];
            we_q    <= (cmd_i == CMD_MEM_WR);
            wide_q  <= wide_req;
            win_q   <= hit;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_DATA: begin
          if (xfer) begin
            rdy_q <= 1'b0;
            if (cyc_ni) state_q <= ST_IDLE;
            else        addr_q  <= addr_q + step;
          end else if (loc_req_o && loc_ack_i) begin
            rdy_q <= 1'b1;
            if (!we_q) rdata_q <= loc_rdata_i;
          end else if (expire) begin
            state_q <= ST_STOP;
          end
        end
        ST_STOP: if (cyc_ni) state_q <= ST_SKIP;
        ST_SKIP: if (cyc_ni && irdy_ni) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign claim_no    = !claimed;
  assign tgt_rdy_no  = !((state_q == ST_DATA) && rdy_q);
  assign tgt_stop_no = (state_q != ST_STOP);
  assign wack_no     = !(claimed && wide_q);
  assign ad_o        = rdata_q;
  assign ad_oe_o     = (state_q == ST_DATA) && !we_q;
  assign loc_we_o    = we_q;
  assign loc_addr_o  = addr_q;
  assign loc_win_o   = win_q;
  assign loc_wdata_o = ad_i;
endmodule

// File: rtl/pcit_chk.sv
module pcit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cyc_ni,
  input logic        irdy_ni,
  input logic        claim_no,
  input logic        tgt_rdy_no,
  input logic        tgt_stop_no,
  input logic        wack_no,
  input logic        loc_req_o,
  input logic        loc_we_o,
  input logic        loc_ack_i,
  input logic [31:0] loc_addr_o
);
  AST_RDY_STOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!tgt_rdy_no && !tgt_stop_no)); // R10

  AST_RDY_NEEDS_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_rdy_no |-> !claim_no); // R4

  AST_RDY_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_rdy_no) |-> $past(loc_ack_i)); // R4

  AST_WR_REQ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_req_o && loc_we_o) |-> !irdy_ni); // R5

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!claim_no && !irdy_ni && !tgt_rdy_no && !cyc_ni) |=>
      (loc_addr_o == $past(loc_addr_o) + ($past(wack_no) ? 32'd4 : 32'd8))); // R6

  AST_WACK_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wack_no |-> !claim_no); // R7

  AST_LAST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_ni && !irdy_ni && !tgt_rdy_no) |=>
      (claim_no && tgt_rdy_no && tgt_stop_no && wack_no)); // R8

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tgt_stop_no && !cyc_ni) |=> !tgt_stop_no); // R9

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tgt_stop_no && cyc_ni) |=> tgt_stop_no); // R9
endmodule

bind pcit_target pcit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_ni      (cyc_ni),
  .irdy_ni     (irdy_ni),
  .claim_no    (claim_no),
  .tgt_rdy_no  (tgt_rdy_no),
  .tgt_stop_no (tgt_stop_no),
  .wack_no     (wack_no),
  .loc_req_o   (loc_req_o),
  .loc_we_o    (loc_we_o),
  .loc_ack_i   (loc_ack_i),
  .loc_addr_o  (loc_addr_o)
);

// File: tb/sim_pcit_target.sv
module sim_pcit_target;
  localparam int TMO = 8;
  localparam int DW  = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cyc_ni = 1'b1, irdy_ni = 1'b1, wreq_ni = 1'b1, loc_ack_i = 1'b0;
  logic [DW-1:0] ad_i = '0, loc_rdata_i = '0;
  logic [3:0]    cmd_i = '0;
  logic [DW-1:0] ad_o, loc_wdata_o;
  logic          ad_oe_o, claim_no, tgt_rdy_no, tgt_stop_no, wack_no, loc_req_o, loc_we_o;
  logic [31:0]   loc_addr_o;
  logic [1:0]    loc_win_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pcit_target #(.TMO(TMO)) u0 (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    @(negedge clk_i);
    cyc_ni = 1'b1; irdy_ni = 1'b1; wreq_ni = 1'b1; loc_ack_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    check("R1 claim", claim_no, 1); check("R1 trdy", tgt_rdy_no, 1);
    check("R1 stop", tgt_stop_no, 1); check("R1 wack", wack_no, 1);
    check("R1 req", loc_req_o, 0); check("R1 oe", ad_oe_o, 0);
  endtask

  task automatic t_read32();
    @(negedge clk_i);
    cyc_ni = 0; ad_i = 64'h1_0010; cmd_i = 4'b0110; wreq_ni = 1; irdy_ni = 1;
    @(negedge clk_i);
    check("R2 claim", claim_no, 0); check("R2 addr", loc_addr_o, 32'h1_0010);
    check("R2 win0", loc_win_o, 2'b01); check("R7 no wack", wack_no, 1);
    check("R4 rd req", loc_req_o, 1); check("R4 rd we", loc_we_o, 0);
    ad_i = '0; loc_ack_i = 1; loc_rdata_i = 64'hA5A5_0001_1234_5678;
    @(negedge clk_i);
    loc_ack_i = 0;
    check("R4 trdy", tgt_rdy_no, 0); check("R4 data", ad_o, 64'hA5A5_0001_1234_5678);
    check("R4 oe", ad_oe_o, 1);
    @(negedge clk_i);
    check("R4 hold trdy", tgt_rdy_no, 0); check("R4 no xfer", loc_addr_o, 32'h1_0010);
    irdy_ni = 0;
    @(negedge clk_i);
    check("R6 trdy up", tgt_rdy_no, 1); check("R6 step4", loc_addr_o, 32'h1_0014);
    check("R6 claim", claim_no, 0);
    loc_ack_i = 1; loc_rdata_i = 64'h0000_0000_CAFE_0002; cyc_ni = 1;
    @(negedge clk_i);
    loc_ack_i = 0;
    check("R4 trdy2", tgt_rdy_no, 0); check("R4 data2", ad_o, 64'hCAFE_0002);
    @(negedge clk_i);
    check("R8 claim", claim_no, 1); check("R8 trdy", tgt_rdy_no, 1);
    check("R8 stop", tgt_stop_no, 1); check("R8 oe", ad_oe_o, 0);
    irdy_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic t_write64();
    @(negedge clk_i);
    cyc_ni = 0; ad_i = 64'h2_0008; cmd_i = 4'b0111; wreq_ni = 0; irdy_ni = 1;
    @(negedge clk_i);
    check("R2 claim wr", claim_no, 0); check("R2 win1", loc_win_o, 2'b10);
    check("R7 wack", wack_no, 0); check("R5 no req", loc_req_o, 0);
    irdy_ni = 0; ad_i = 64'h1111_2222_3333_4444; #1;
    check("R5 req", loc_req_o, 1); check("R5 we", loc_we_o, 1);
    check("R5 wdata", loc_wdata_o, 64'h1111_2222_3333_4444);
    loc_ack_i = 1;
    @(negedge clk_i);
    loc_ack_i = 0;
    check("R5 trdy", tgt_rdy_no, 0); check("R5 req off", loc_req_o, 0);
    @(negedge clk_i);
    check("R6 step8", loc_addr_o, 32'h2_0010); check("R6 trdy up", tgt_rdy_no, 1);
    ad_i = 64'h5555_6666_7777_8888; cyc_ni = 1; #1;
    check("R5 wdata2", loc_wdata_o, 64'h5555_6666_7777_8888);
    loc_ack_i = 1;
    @(negedge clk_i);
    loc_ack_i = 0;
    check("R5 trdy2", tgt_rdy_no, 0);
    @(negedge clk_i);
    check("R8 claim wr", claim_no, 1); check("R8 wack", wack_no, 1);
    irdy_ni = 1; wreq_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic t_miss(input logic [31:0] addr, input logic [3:0] cmd, input string tag);
    @(negedge clk_i);
    cyc_ni = 0; ad_i = {32'h0, addr}; cmd_i = cmd; irdy_ni = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check({"R3 claim ", tag}, claim_no, 1); check({"R3 req ", tag}, loc_req_o, 0);
      irdy_ni = 0;
    end
    cyc_ni = 1;
    @(negedge clk_i);
    check({"R3 claim end ", tag}, claim_no, 1);
    irdy_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic t_timeout();
    @(negedge clk_i);
    cyc_ni = 0; ad_i = 64'h1_0100; cmd_i = 4'b0110; irdy_ni = 1;
    for (int i = 1; i <= TMO; i++) begin
      @(negedge clk_i);
      check("R9 no stop yet", tgt_stop_no, 1);
      irdy_ni = 0;
    end
    @(negedge clk_i);
    check("R9 stop", tgt_stop_no, 0); check("R10 trdy high", tgt_rdy_no, 1);
    check("R9 claim", claim_no, 0);
    @(negedge clk_i);
    check("R9 stop held", tgt_stop_no, 0);
    cyc_ni = 1;
    @(negedge clk_i);
    check("R9 stop rel", tgt_stop_no, 1); check("R9 claim rel", claim_no, 1);
    irdy_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_read32();
    idle_bus();
    t_write64();
    idle_bus();
    t_miss(32'h0003_0000, 4'b0110, "window");
    t_miss(32'h0001_0000, 4'b0010, "command");
    t_timeout();
    idle_bus();
    t_read32();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule